// File: doc/BRIEF.md
# Per-Channel Output Control and Serializer

This block sits at the output side of a time-slot switch with 8 serial streams. Each stream carries 32 channels of 8 bits per frame. Every output channel has a 3-bit high control entry and an 8-bit low entry, both held in connection memories inside the block. For each bit time, the block uses these entries to decide three things: whether the stream's output drives or floats, whether it carries switched data or a byte supplied by the host, and what value a separate control serial line carries.

A slot counter runs one bit time per clock and steps through the frame with the most significant bit first. The frame sync input aligns it to channel 0. For switched channels, the low entry names a source stream and channel. The block presents that address to an external data memory and takes the returned byte in the same cycle. A global output-disable pin and a global processor-enable bit act on top of the per-channel bits.

The control line carries one bit per channel per stream, 256 bits per frame. It runs one full channel ahead of the data so that external circuitry has time to act. Within each channel time, the bits for the next channel are interleaved across the 8 streams in stream order.

Top module: `tsi_out_ctl`

## Requirements
- R1: While `rst` is high, `tx_data`, `tx_oe` and `ctl_out` are all 0 at the following edge, every connection-memory entry is cleared, and the slot position returns to channel 0, bit 7.
- R2: The slot position starts at channel 0, bit 7. Each clock moves it down one bit, from bit 7 to bit 0. After bit 0 it moves to bit 7 of the next channel, and after channel 31 it wraps to channel 0. `fsync` high forces channel 0, bit 7 at the next position.
- R3: With `ode` high, `pe` low, high entry bit 2 clear and bit 0 set, the stream drives (`tx_oe`=1). It sends bit b of `dm_byte` for its lane, where b is the current bit position.
- R4: When high entry bit 2 is set, the stream sends bit b of the channel's own low entry instead of switched data.
- R5: When `pe` is high, every channel behaves as if bits 2 and 0 of its high entry were set, whatever was stored.
- R6: When `ode` is low, every `tx_oe` bit is 0 and every `tx_data` bit is 0.
- R7: With `ode` high and `pe` low, a channel whose high entry bit 0 is clear floats (`tx_oe`=0, `tx_data`=0).
- R8: At slot position (c, b), `ctl_out` carries bit 1 of the high entry of stream 7−b, channel c+1.
- R9: In channel 31, the control line carries the bits for channel 0, so channel 0's control bits go out at the end of the previous frame.
- R10: When `cm_we` is high, a write to the entry (`cm_stream`, `cm_chan`) takes effect from the next edge. `cm_hi`=1 selects the high memory, which uses `cm_wdata[2:0]`; `cm_hi`=0 selects the low memory.
- R11: Lane s of `src_addr` equals the low entry of stream s at the current channel. Bits [7:5] of that entry are the source stream and bits [4:0] are the source channel.
- R12: `tx_data`, `tx_oe` and `ctl_out` are registered. Each reflects the slot position and inputs of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame alignment pulse |
| ode | input | 1 | Global output enable (low floats all streams) |
| pe | input | 1 | Global processor-mode enable |
| cm_we | input | 1 | Connection memory write strobe |
| cm_hi | input | 1 | 1 selects the high memory, 0 the low memory |
| cm_stream | input | 3 | Write stream index |
| cm_chan | input | 5 | Write channel index |
| cm_wdata | input | 8 | Write data |
| src_addr | output | 64 | Per-lane source address {stream, channel} for the current slot |
| dm_byte | input | 64 | Per-lane switched byte returned for `src_addr` |
| tx_data | output | 8 | Serial data, one bit per stream |
| tx_oe | output | 8 | Per-stream drive enable |
| ctl_out | output | 1 | Control serial line |

## Verification
The bench goes after four corner cases:
- **Control-line indexing.** A design that used the current channel instead of the next one, or reversed the stream order, would put the wrong high entry on `ctl_out` at every bit.
- **Frame wrap.** The control bits sent in channel 31 must belong to channel 0. A design that forgot the modulo would read a channel past the end.
- **Precedence.** A design that let a stored entry override `pe`, or let a channel drive while `ode` is low, would show up as data on a floated or disabled lane.
- **Mid-frame realignment and writes during traffic.** These check that `fsync` restarts the position and that new entries take effect at the very next slot that reads them.

// File: rtl/tsi_ctl_pkg.sv
package tsi_ctl_pkg;

    parameter int STREAMS = 8;
    parameter int CHANS   = 32;
    parameter int BYTE_W  = 8;

    localparam int SW = $clog2(STREAMS);
    localparam int CW = $clog2(CHANS);
    localparam int BW = $clog2(BYTE_W);
    localparam int HI_W = 3;

    typedef struct packed {
        logic [CW-1:0] ch;
        logic [BW-1:0] bt;
    } slot_pos_t;

    // high entry layout: bit 2 source select, bit 1 control bit, bit 0 enable
    typedef struct packed {
        logic src;
        logic ctl;
        logic oe;
    } hi_ent_t;

    typedef struct packed {
        logic [SW-1:0] stream;
        logic [CW-1:0] ch;
    } src_addr_t;

    typedef struct packed {
        logic drive;
        logic bit_val;
    } lane_out_t;

    function automatic slot_pos_t frame_start();
        slot_pos_t p;
        p.ch = '0;
        p.bt = BW'(BYTE_W - 1);
        return p;
    endfunction

    function automatic logic [CW-1:0] next_chan(input logic [CW-1:0] ch);
        return (ch == CW'(CHANS - 1)) ? '0 : ch + 1'b1;
    endfunction

    function automatic slot_pos_t step_pos(input slot_pos_t p);
        slot_pos_t n;
        if (p.bt == '0) begin
            n.bt = BW'(BYTE_W - 1);
            n.ch = next_chan(p.ch);
        end else begin
            n.bt = p.bt - 1'b1;
            n.ch = p.ch;
        end
        return n;
    endfunction

    // bit 7 carries stream 0, bit 0 carries the last stream
    function automatic logic [SW-1:0] ctl_stream(input logic [BW-1:0] bt);
        return SW'(BYTE_W - 1 - int'(bt));
    endfunction

endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
    import tsi_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fsync,
    output slot_pos_t pos
);

    always_ff @(posedge clk) begin
        if (rst)        pos <= frame_start();
        else if (fsync) pos <= frame_start();
        else            pos <= step_pos(pos);
    end

    assert_fsync_align_R2: assert property (@(posedge clk) disable iff (rst)
        fsync |=> (pos.ch == '0 && pos.bt == BW'(BYTE_W - 1)));

    assert_bit_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!fsync && pos.bt != '0) |=> (pos.bt == $past(pos.bt) - 1'b1 && $stable(pos.ch)));

endmodule

// File: rtl/tsi_cm_store.sv
module tsi_cm_store
    import tsi_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic                sel_hi,
    input  logic [SW-1:0]       wr_stream,
    input  logic [CW-1:0]       wr_chan,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [CW-1:0]       rd_chan,
    output hi_ent_t             hi_rd [STREAMS],
    output logic [BYTE_W-1:0]   lo_rd [STREAMS],
    input  logic [SW-1:0]       ctl_rd_stream,
    input  logic [CW-1:0]       ctl_rd_chan,
    output logic                ctl_rd_bit
);

    hi_ent_t           hi_mem [STREAMS][CHANS];
    logic [BYTE_W-1:0] lo_mem [STREAMS][CHANS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STREAMS; s++) begin
                for (int c = 0; c < CHANS; c++) begin
                    hi_mem[s][c] <= '0;
                    lo_mem[s][c] <= '0;
                end
            end
        end else if (we) begin
            if (sel_hi) hi_mem[wr_stream][wr_chan] <= hi_ent_t'(wr_data[HI_W-1:0]);
            else        lo_mem[wr_stream][wr_chan] <= wr_data;
        end
    end

    for (genvar s = 0; s < STREAMS; s++) begin : g_rd
        assign hi_rd[s] = hi_mem[s][rd_chan];
        assign lo_rd[s] = lo_mem[s][rd_chan];
    end

    assign ctl_rd_bit = hi_mem[ctl_rd_stream][ctl_rd_chan].ctl;

    assert_hi_write_R10: assert property (@(posedge clk) disable iff (rst)
        (we && sel_hi) |=> (hi_mem[$past(wr_stream)][$past(wr_chan)] == hi_ent_t'($past(wr_data[HI_W-1:0]))));

endmodule

// File: rtl/tsi_lane_ctrl.sv
module tsi_lane_ctrl
    import tsi_ctl_pkg::*;
(
    input  hi_ent_t             hi,
    input  logic [BYTE_W-1:0]   lo,
    input  logic [BYTE_W-1:0]   switched,
    input  logic [BW-1:0]       bt,
    input  logic                ode,
    input  logic                pe,
    output src_addr_t           src,
    output lane_out_t           lane
);

    logic              host_mode;
    logic              enabled;
    logic [BYTE_W-1:0] out_byte;

    assign src       = src_addr_t'(lo);
    assign host_mode = pe | hi.src;
    assign enabled   = ode & (pe | hi.oe);
    assign out_byte  = host_mode ? lo : switched;

    always_comb begin
        lane.drive   = enabled;
        lane.bit_val = enabled & out_byte[bt];
    end

endmodule

// File: rtl/tsi_out_ctl.sv
module tsi_out_ctl
    import tsi_ctl_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fsync,
    input  logic                        ode,
    input  logic                        pe,
    input  logic                        cm_we,
    input  logic                        cm_hi,
    input  logic [SW-1:0]               cm_stream,
    input  logic [CW-1:0]               cm_chan,
    input  logic [BYTE_W-1:0]           cm_wdata,
    output logic [STREAMS*BYTE_W-1:0]   src_addr,
    input  logic [STREAMS*BYTE_W-1:0]   dm_byte,
    output logic [STREAMS-1:0]          tx_data,
    output logic [STREAMS-1:0]          tx_oe,
    output logic                        ctl_out
);

    slot_pos_t         pos;
    hi_ent_t           hi_rd [STREAMS];
    logic [BYTE_W-1:0] lo_rd [STREAMS];
    lane_out_t         lane  [STREAMS];
    logic              ctl_bit;
    logic [STREAMS-1:0] nxt_data;
    logic [STREAMS-1:0] nxt_oe;

    tsi_slot_timer u_timer (
        .clk   (clk),
        .rst   (rst),
        .fsync (fsync),
        .pos   (pos)
    );

    tsi_cm_store u_store (
        .clk           (clk),
        .rst           (rst),
        .we            (cm_we),
        .sel_hi        (cm_hi),
        .wr_stream     (cm_stream),
        .wr_chan       (cm_chan),
        .wr_data       (cm_wdata),
        .rd_chan       (pos.ch),
        .hi_rd         (hi_rd),
        .lo_rd         (lo_rd),
        .ctl_rd_stream (ctl_stream(pos.bt)),
        .ctl_rd_chan   (next_chan(pos.ch)),
        .ctl_rd_bit    (ctl_bit)
    );

    for (genvar s = 0; s < STREAMS; s++) begin : g_lane
        src_addr_t a;
        tsi_lane_ctrl u_lane (
            .hi       (hi_rd[s]),
            .lo       (lo_rd[s]),
            .switched (dm_byte[s*BYTE_W +: BYTE_W]),
            .bt       (pos.bt),
            .ode      (ode),
            .pe       (pe),
            .src      (a),
            .lane     (lane[s])
        );
        assign src_addr[s*BYTE_W +: BYTE_W] = a;
        assign nxt_data[s] = lane[s].bit_val;
        assign nxt_oe[s]   = lane[s].drive;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_data <= '0;
            tx_oe   <= '0;
            ctl_out <= 1'b0;
        end else begin
            tx_data <= nxt_data;
            tx_oe   <= nxt_oe;
            ctl_out <= ctl_bit;
        end
    end

    assert_float_all_R6: assert property (@(posedge clk) disable iff (rst)
        !ode |=> (tx_oe == '0));

    assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        ((tx_data & ~tx_oe) == '0));

    assert_pe_drives_R5: assert property (@(posedge clk) disable iff (rst)
        (pe && ode) |=> (tx_oe == '1));

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (tx_oe == '0 && ctl_out == 1'b0));

endmodule

// File: tb/test_tsi_out_ctl.sv
module test_tsi_out_ctl;

    localparam int NS = 8;
    localparam int NC = 32;

    logic clk = 0;
    logic rst, fsync, ode, pe, cm_we, cm_hi;
    logic [2:0] cm_stream;
    logic [4:0] cm_chan;
    logic [7:0] cm_wdata;
    logic [NS*8-1:0] src_addr, dm_byte;
    logic [NS-1:0] tx_data, tx_oe;
    logic ctl_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tsi_out_ctl i_tsi_out_ctl (
        .clk(clk), .rst(rst), .fsync(fsync), .ode(ode), .pe(pe),
        .cm_we(cm_we), .cm_hi(cm_hi), .cm_stream(cm_stream), .cm_chan(cm_chan),
        .cm_wdata(cm_wdata), .src_addr(src_addr), .dm_byte(dm_byte),
        .tx_data(tx_data), .tx_oe(tx_oe), .ctl_out(ctl_out)
    );

    function automatic logic [7:0] dm_fn(input logic [7:0] a);
        return a * 8'd37 + 8'd11;
    endfunction

    // external data memory model
    always_comb begin
        for (int s = 0; s < NS; s++) dm_byte[s*8 +: 8] = dm_fn(src_addr[s*8 +: 8]);
    end

    // reference model state
    logic [2:0] m_hi [NS][NC];
    logic [7:0] m_lo [NS][NC];
    int m_ch, m_bt;
    logic [NS-1:0] e_data, e_oe;
    logic e_ctl;
    string e_tag [NS];
    string e_ctl_tag;

    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NS; s++)
                for (int c = 0; c < NC; c++) begin m_hi[s][c] = 0; m_lo[s][c] = 0; end
            e_data = 0; e_oe = 0; e_ctl = 0;
            for (int s = 0; s < NS; s++) e_tag[s] = "R1";
            e_ctl_tag = "R1";
            m_ch = 0; m_bt = 7;
        end else begin
            for (int s = 0; s < NS; s++) begin
                logic [2:0] h;
                logic [7:0] b;
                logic host, en;
                h = m_hi[s][m_ch];
                host = pe | h[2];
                en = ode & (pe | h[0]);
                b = host ? m_lo[s][m_ch] : dm_fn(m_lo[s][m_ch]);
                e_oe[s] = en;
                e_data[s] = en & b[m_bt];
                if (!ode) e_tag[s] = "R6";
                else if (pe) e_tag[s] = "R5";
                else if (h[2]) e_tag[s] = "R4";
                else if (!h[0]) e_tag[s] = "R7";
                else e_tag[s] = "R3";
                if (cm_we) e_tag[s] = {e_tag[s], "/R10"};
            end
            e_ctl = m_hi[7 - m_bt][(m_ch + 1) % NC][1];
            e_ctl_tag = (m_ch == NC - 1) ? "R9" : "R8";
            if (fsync) e_ctl_tag = {e_ctl_tag, "/R2"};
            if (cm_we) begin
                if (cm_hi) m_hi[cm_stream][cm_chan] = cm_wdata[2:0];
                else       m_lo[cm_stream][cm_chan] = cm_wdata;
            end
            if (fsync) begin m_ch = 0; m_bt = 7; end
            else if (m_bt == 0) begin m_bt = 7; m_ch = (m_ch + 1) % NC; end
            else m_bt = m_bt - 1;
        end
    end

    // compare away from the active edge (R12: outputs lag the position by one clock)
    always @(negedge clk) begin
        if (!done && $time > 6) begin
            for (int s = 0; s < NS; s++) begin
                checks++;
                if (tx_oe[s] !== e_oe[s] || tx_data[s] !== e_data[s]) begin
                    errors++;
                    $display("FAIL %s R12 lane %0d: oe/data %b%b expected %b%b", e_tag[s], s,
                             tx_oe[s], tx_data[s], e_oe[s], e_data[s]);
                end
                if (!rst) begin
                    checks++;
                    if (src_addr[s*8 +: 8] !== m_lo[s][m_ch]) begin
                        errors++;
                        $display("FAIL R11 lane %0d: src %h expected %h", s,
                                 src_addr[s*8 +: 8], m_lo[s][m_ch]);
                    end
                end
            end
            checks++;
            if (ctl_out !== e_ctl) begin
                errors++;
                $display("FAIL %s ctl_out: %b expected %b", e_ctl_tag, ctl_out, e_ctl);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic hi, input int s, input int c, input logic [7:0] d);
        cm_we = 1; cm_hi = hi; cm_stream = 3'(s); cm_chan = 5'(c); cm_wdata = d;
        @(negedge clk);
        cm_we = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1; fsync = 0; ode = 0; pe = 0;
        cm_we = 0; cm_hi = 0; cm_stream = 0; cm_chan = 0; cm_wdata = 0;
        tick(4);
        // R1: reset state of outputs
        checks++;
        if (tx_oe !== 0 || tx_data !== 0 || ctl_out !== 0) begin
            errors++;
            $display("FAIL R1 reset outputs %b %b %b expected 0", tx_oe, tx_data, ctl_out);
        end
        rst = 0;
        // R10, R11: program every entry while floated (R6)
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++) begin
                wr(1'b0, s, c, 8'(s * 41 + c * 7 + 3));
                wr(1'b1, s, c, 8'((s * 5 + c * 3) % 8));
            end
        tick(256);
        // R3, R4, R7, R8, R9: per-channel control
        ode = 1;
        tick(512);
        // R5: processor mode forced globally
        pe = 1;
        tick(256);
        pe = 0;
        // R2: realign mid-frame, repeated
        tick(77);
        fsync = 1; tick(1); fsync = 0;
        tick(140);
        fsync = 1; tick(1); fsync = 0;
        tick(300);
        // R10: rewrite entries during traffic
        for (int i = 0; i < 64; i++) begin
            wr(1'b1, i % NS, (i * 5) % NC, 8'(i));
            wr(1'b0, i % NS, (i * 5) % NC, 8'(i * 29));
        end
        tick(256);
        ode = 0; tick(20); ode = 1;
        // R1: reset mid-run clears memories
        rst = 1; tick(2); rst = 0;
        tick(300);
        finish_run();
    end

endmodule